// File: doc/BRIEF.md
# Variable-Length Instruction Address Updater

This block keeps a 64-bit program status doubleword whose low-order 24-bit field holds the address of the next instruction. Each fetch strobe carries the first opcode byte of the instruction being fetched. The block decodes the instruction length (one, two or three halfwords) from the two leading opcode bits and adds it to the address field. The result then points to the following sequential instruction before the current one executes.

Surrounding control logic can replace the address field alone, as a branch, or replace the whole doubleword, as a new status load. The doubleword is internal state and is shown on a read port, along with a separate port for the address field. An alignment flag rises whenever the held address is odd. Storage access, execution, the other status fields and interrupts belong to other blocks.

Top module: `iaddr_step`

Bit numbering follows the status-word convention: status bit 0 is the most significant bit. Status bits 40 to 63 therefore map to `psw_o[23:0]`, and status bit 63 is `psw_o[0]`. Opcode bits 0 and 1 are `opcode_i[7:6]`.

## Requirements
- R1: After reset, `psw_o` is all zeros and `misalign_o` is low.
- R2: A fetch (`fetch_i` high, no load) adds a step to `psw_o[23:0]` on the next clock edge. The step is chosen by `opcode_i[7:6]`: 00 gives 2, 01 and 10 give 4, and 11 gives 6. The other opcode bits have no effect.
- R3: The address addition wraps modulo 2^24. For example, 0xFFFFFE plus 6 gives 0x000004.
- R4: Fetches and branch loads leave `psw_o[63:24]` (status bits 0 to 39) unchanged.
- R5: When `branch_i` is high, `psw_o[23:0]` takes the value of `target_i` on the next edge.
- R6: When `load_word_i` is high, all 64 bits of `psw_o` take the value of `word_i` on the next edge.
- R7: Priority when several strobes are high in one cycle: a full load beats a branch, and a branch beats a fetch. The losing actions have no effect.
- R8: `misalign_o` is high in every cycle in which `psw_o[0]` is 1 (an odd address). The address is never corrected, so a fetch from an odd address keeps it odd.
- R9: With no strobe high, `psw_o` holds its value.
- R10: `addr_o` always equals `psw_o[23:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_i | input | 1 | Instruction fetch strobe |
| opcode_i | input | 8 | Opcode byte of the fetched instruction |
| load_word_i | input | 1 | Full status word load strobe |
| word_i | input | 64 | New status doubleword |
| branch_i | input | 1 | Address field load strobe |
| target_i | input | 24 | Branch target address |
| psw_o | output | 64 | Current status doubleword |
| addr_o | output | 24 | Next-instruction address field |
| misalign_o | output | 1 | Odd address flag |

## Verification
Fetches, branches and full loads each change `psw_o` and `addr_o` exactly one clock edge after the strobe is sampled. `misalign_o` follows the stored address in the same cycle, with no further register delay. The bench drives every strobe on a falling edge and releases it on the next falling edge. It compares results at that falling edge, half a period after the updating rising edge, against a reference word that it advances arithmetically. All 256 opcode values are swept from several start addresses, including some just below the wrap point.

// File: rtl/iaddr_step.sv
module iaddr_step #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_i,
  input  logic [7:0]        opcode_i,
  input  logic              load_word_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              branch_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [WORD_W-1:0] psw_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              misalign_o
);
  localparam int HI_W = WORD_W - ADDR_W;

  logic [WORD_W-1:0] psw_q;
  logic [ADDR_W-1:0] step;

  always_comb begin
    unique case (opcode_i[7:6])
      2'b00:   step = ADDR_W'(2);
      2'b11:   step = ADDR_W'(6);
      default: step = ADDR_W'(4);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           psw_q <= '0;
    else if (load_word_i) psw_q <= word_i;
    else if (branch_i)    psw_q[ADDR_W-1:0] <= target_i;
    else if (fetch_i)     psw_q[ADDR_W-1:0] <= psw_q[ADDR_W-1:0] + step;
  end

  assign psw_o      = psw_q;
  assign addr_o     = psw_q[ADDR_W-1:0];
  assign misalign_o = psw_q[0];

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = psw_q[WORD_W-1:ADDR_W];
endmodule

module iaddr_step_chk #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_i,
  input logic [7:0]        opcode_i,
  input logic              load_word_i,
  input logic [WORD_W-1:0] word_i,
  input logic              branch_i,
  input logic [ADDR_W-1:0] target_i,
  input logic [WORD_W-1:0] psw_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              misalign_o
);
  logic [ADDR_W-1:0] exp_step;
  assign exp_step = (opcode_i[7:6] == 2'b00) ? ADDR_W'(2) :
                    (opcode_i[7:6] == 2'b11) ? ADDR_W'(6) : ADDR_W'(4);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && !branch_i && !load_word_i) |=> addr_o == $past(addr_o) + $past(exp_step));
  p_keep_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_word_i |=> psw_o[WORD_W-1:ADDR_W] == $past(psw_o[WORD_W-1:ADDR_W]));
  p_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_i && !load_word_i) |=> addr_o == $past(target_i));
  p_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_word_i |=> psw_o == $past(word_i));
  p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && !branch_i && !load_word_i) |=> misalign_o == $past(misalign_o));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_i && !branch_i && !load_word_i) |=> $stable(psw_o));
  p_view_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_o == psw_o[ADDR_W-1:0] && misalign_o == addr_o[0]);
endmodule

bind iaddr_step iaddr_step_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/iaddr_step_test.sv
module iaddr_step_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic        load_word_i = 1'b0;
  logic [63:0] word_i = '0;
  logic        branch_i = 1'b0;
  logic [23:0] target_i = '0;
  logic [63:0] psw_o;
  logic [23:0] addr_o;
  logic        misalign_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] model = '0;

  always #4 clk = ~clk;

  iaddr_step uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit f, input logic [7:0] op, input bit lw,
                     input logic [63:0] w, input bit br, input logic [23:0] t);
    fetch_i = f; opcode_i = op; load_word_i = lw; word_i = w; branch_i = br; target_i = t;
    @(negedge clk);
    fetch_i = 0; load_word_i = 0; branch_i = 0;
  endtask

  function automatic logic [23:0] stp(input logic [7:0] op);
    return (op[7:6] == 2'b00) ? 24'd2 : (op[7:6] == 2'b11) ? 24'd6 : 24'd4;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [23:0] starts [5];
    starts = '{24'h000000, 24'd1000, 24'hFFFFFE, 24'hFFFFFA, 24'h123456};
    repeat (2) @(negedge clk);
    chk("R1", psw_o, 64'h0);
    chk("R1", {63'h0, misalign_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // worked example: 1000 -> 1002 -> 1006
    cyc(0, 0, 0, 0, 1, 24'd1000);
    cyc(1, 8'h1A, 0, 0, 0, 0);
    chk("R2", {40'h0, addr_o}, 64'd1002);
    cyc(1, 8'h5A, 0, 0, 0, 0);
    chk("R2", {40'h0, addr_o}, 64'd1006);

    // full load sets upper bits, then sweep all opcodes from several starts
    model = 64'hA5C3_0F1E_7700_0000;
    cyc(0, 0, 1, model, 0, 0);
    chk("R6", psw_o, model);
    for (int s = 0; s < 5; s++) begin
      for (int op = 0; op < 256; op++) begin
        cyc(0, 0, 0, 0, 1, starts[s]);
        model[23:0] = starts[s];
        chk("R5", psw_o, model);
        cyc(1, op[7:0], 0, 0, 0, 0);
        model[23:0] = model[23:0] + stp(op[7:0]);
        chk("R2 R3 R4", psw_o, model);
        chk("R10", {40'h0, addr_o}, {40'h0, psw_o[23:0]});
      end
    end

    // wrap explicit
    cyc(0, 0, 0, 0, 1, 24'hFFFFFE);
    cyc(1, 8'hC0, 0, 0, 0, 0);
    chk("R3", {40'h0, addr_o}, 64'h4);

    // idle hold
    repeat (3) @(negedge clk);
    chk("R9", psw_o, {model[63:24], 24'h4});

    // priority: full load beats branch and fetch
    cyc(1, 8'hC0, 1, 64'h1111_2222_3333_4444, 1, 24'h00BEEF);
    chk("R7", psw_o, 64'h1111_2222_3333_4444);
    // branch beats fetch
    cyc(1, 8'hC0, 0, 0, 1, 24'h000100);
    chk("R7", psw_o, 64'h1111_2222_3300_0100);

    // odd address
    cyc(0, 0, 0, 0, 1, 24'h000201);
    chk("R8", {63'h0, misalign_o}, 64'h1);
    cyc(1, 8'h80, 0, 0, 0, 0);
    chk("R8", {40'h0, addr_o}, 64'h205);
    chk("R8", {63'h0, misalign_o}, 64'h1);
    cyc(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0);
    chk("R8", {63'h0, misalign_o}, 64'h0);
    chk("R6", psw_o, 64'hFFFF_FFFF_FFFF_FFF0);

    // reset again
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", psw_o, 64'h0);
    finish_run();
  end
endmodule